// File: doc/BRIEF.md
# Move, Sign-Extend and Byte-Swap Execution Slice

This block is one execution slice of the integer unit of a 64-bit register machine. It handles three operation groups: register or immediate moves, sign-extending moves from a narrower source field, and unconditional byte reversal. It also handles two's-complement negation. Each operation exists in a 64-bit class (class code 0x7) and a 32-bit class (class code 0x4). A 32-bit result is always zero-extended into the full 64-bit destination.

The slice is purely combinational. The issue stage presents a decoded instruction together with the destination and source register values. In the same cycle the slice returns the 64-bit result, a write-enable for the register file and an illegal-instruction flag. An instruction outside the slice's operation set raises neither output, so other slices can claim it.

The move variant is selected by the 16-bit offset field. The byte-swap width is selected by the immediate.

Top module: `mvx_swap_unit`

## Requirements
- R1: While `in_valid` is 0, `out_wr_en` and `out_illegal` are 0 and `out_result` is 0.
- R2: Class 0x7, opcode 0xb, offset 0 (plain move) writes the operand. The operand is `in_src` when `in_src_reg` is 1, and the 32-bit immediate sign-extended to 64 bits when `in_src_reg` is 0.
- R3: Class 0x4, opcode 0xb, offset 0 writes the low 32 bits of the operand, zero-extended to 64 bits.
- R4: Class 0x7, opcode 0xb with `in_src_reg`=1 writes `in_src` bits [7:0], [15:0] or [31:0], sign-extended to 64 bits, for offset 8, 16 or 32 respectively.
- R5: Class 0x4, opcode 0xb with `in_src_reg`=1 writes `in_src` bits [7:0] (offset 8) or [15:0] (offset 16), sign-extended to 32 bits and then zero-extended to 64 bits.
- R6: The following opcode-0xb cases raise `out_illegal` with no write:
  - an offset other than 0, 8, 16 or 32;
  - offset 32 in class 0x4;
  - any nonzero offset with `in_src_reg`=0.
- R7: Class 0x7, opcode 0xd with `in_src_reg`=0 reverses the byte order of the destination's low 2, 4 or 8 bytes, for immediate 0x10, 0x20 or 0x40 respectively. All bits above the swapped field are 0.
- R8: Class 0x7, opcode 0xd raises `out_illegal` with no write when the immediate is not 0x10, 0x20 or 0x40, or when `in_src_reg` is 1.
- R9: Opcode 0x8 with `in_src_reg`=0 writes the two's-complement negation of `in_dst`. Class 0x4 zero-extends the negated low 32 bits. With `in_src_reg`=1 this opcode is illegal.
- R10: Any other opcode, any class other than 0x4 or 0x7, and opcode 0xd in class 0x4 raise neither `out_wr_en` nor `out_illegal`.
- R11: `out_wr_en` and `out_illegal` are never both 1, and `out_result` is 0 whenever `out_wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | An instruction is presented this cycle |
| in_opcode | input | 4 | Operation code |
| in_class | input | 3 | Instruction class (0x7 = 64-bit, 0x4 = 32-bit) |
| in_src_reg | input | 1 | 1 selects the source register, 0 selects the immediate |
| in_offset | input | 16 | Offset field; selects the move variant |
| in_imm | input | 32 | Immediate; operand or byte-swap width |
| in_dst | input | 64 | Current destination register value |
| in_src | input | 64 | Source register value |
| out_result | output | 64 | Value to write to the destination |
| out_wr_en | output | 1 | Write the result this cycle |
| out_illegal | output | 1 | Encoding is in this slice's space but unsupported |

## Verification
The bench builds the slice with its default 64-bit data width, 16-bit offset and 32-bit immediate. At those widths it covers the full offset and immediate decode, including the class-0x4 rejection of offset 32. Source fields are chosen with their sign bit both set and clear, so every sign-extension width is seen extending ones and zeros. The bench also checks the boundary between a swapped field and the cleared upper bits.

// File: rtl/mvx_pkg.sv
// Package: shared encodings and the internal operation kind for the
// move/extend/swap slice. Assumes the field widths of the issue stage.
package mvx_pkg;

    localparam logic [3:0] OPC_MOV = 4'hb;
    localparam logic [3:0] OPC_NEG = 4'h8;
    localparam logic [3:0] OPC_END = 4'hd;

    localparam logic [2:0] CLS_WIDE   = 3'h7;
    localparam logic [2:0] CLS_NARROW = 3'h4;

    // Number of sign-extension widths (8, 16, 32) and of swap widths (16, 32, 64).
    localparam int N_EXT  = 3;
    localparam int N_SWAP = 3;

    typedef enum logic [3:0] {
        K_NONE,
        K_MOV,
        K_SX8,
        K_SX16,
        K_SX32,
        K_NEG,
        K_SW16,
        K_SW32,
        K_SW64,
        K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     narrow;
    } op_dec_t;

endpackage

// File: rtl/mvx_decode.sv
// Module: decodes opcode, class, source select, offset and immediate into an
// operation kind. Assumes the caller gates the result with its valid bit.
module mvx_decode
    import mvx_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic [3:0]       opcode,
    input  logic [2:0]       cls,
    input  logic             src_reg,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    output op_dec_t          dec
);

    localparam logic [OFF_W-1:0] OFF_B = OFF_W'(8);
    localparam logic [OFF_W-1:0] OFF_H = OFF_W'(16);
    localparam logic [OFF_W-1:0] OFF_WD = OFF_W'(32);
    localparam logic [IMM_W-1:0] IMM_16 = IMM_W'(16);
    localparam logic [IMM_W-1:0] IMM_32 = IMM_W'(32);
    localparam logic [IMM_W-1:0] IMM_64 = IMM_W'(64);

    logic in_space;
    logic narrow;

    // Purpose: flag the two classes this slice serves.
    always_comb begin
        narrow   = (cls == CLS_NARROW);
        in_space = (cls == CLS_WIDE) || narrow;
    end

    // Purpose: select the operation kind from opcode and modifier fields.
    always_comb begin
        dec.narrow = narrow;
        dec.kind   = K_NONE;
        if (in_space) begin
            case (opcode)
                OPC_MOV: begin
                    if (offset == '0)
                        dec.kind = K_MOV;
                    else if (!src_reg)
                        dec.kind = K_BAD;
                    else if (offset == OFF_B)
                        dec.kind = K_SX8;
                    else if (offset == OFF_H)
                        dec.kind = K_SX16;
                    else if (offset == OFF_WD && !narrow)
                        dec.kind = K_SX32;
                    else
                        dec.kind = K_BAD;
                end
                OPC_NEG: begin
                    dec.kind = src_reg ? K_BAD : K_NEG;
                end
                OPC_END: begin
                    if (!narrow) begin
                        if (src_reg)
                            dec.kind = K_BAD;
                        else if (imm == IMM_16)
                            dec.kind = K_SW16;
                        else if (imm == IMM_32)
                            dec.kind = K_SW32;
                        else if (imm == IMM_64)
                            dec.kind = K_SW64;
                        else
                            dec.kind = K_BAD;
                    end
                end
                default: dec.kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mvx_sext.sv
// Module: produces the operand sign-extended from each of the 8, 16 and 32
// bit low fields. Assumes DATA_W is larger than the widest field.
module mvx_sext
    import mvx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]             op_in,
    output logic [N_EXT-1:0][DATA_W-1:0]  ext_out
);

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        localparam int FW = 8 << g;
        // Purpose: replicate the field's top bit above the field.
        assign ext_out[g] = {{(DATA_W - FW){op_in[FW-1]}}, op_in[FW-1:0]};
    end

endmodule

// File: rtl/mvx_bswap.sv
// Module: produces the byte-reversed low 2, 4 and 8 byte fields of the
// operand, upper bits cleared. Assumes DATA_W is a multiple of 64.
module mvx_bswap
    import mvx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]             op_in,
    output logic [N_SWAP-1:0][DATA_W-1:0] swp_out
);

    for (genvar g = 0; g < N_SWAP; g++) begin : g_sw
        localparam int NB = 2 << g;
        localparam int FW = NB * 8;
        logic [FW-1:0] field;
        for (genvar b = 0; b < NB; b++) begin : g_byte
            // Purpose: move byte b to the mirrored position.
            assign field[8*b +: 8] = op_in[8*(NB-1-b) +: 8];
        end
        // Purpose: zero-extend the swapped field to the data width.
        assign swp_out[g] = DATA_W'(field);
    end

endmodule

// File: rtl/mvx_swap_unit.sv
// Module: top of the move/extend/swap execution slice. Combinational: result,
// write-enable and illegal flag follow the inputs in the same cycle. Assumes
// the register file samples the outputs at its own clock edge.
module mvx_swap_unit
    import mvx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input  logic              in_valid,
    input  logic [3:0]        in_opcode,
    input  logic [2:0]        in_class,
    input  logic              in_src_reg,
    input  logic [OFF_W-1:0]  in_offset,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_src,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr_en,
    output logic              out_illegal
);

    localparam int HALF_W = DATA_W / 2;

    op_dec_t                          dec;
    logic [DATA_W-1:0]                operand;
    logic [N_EXT-1:0][DATA_W-1:0]     ext_vals;
    logic [N_SWAP-1:0][DATA_W-1:0]    swp_vals;
    logic [DATA_W-1:0]                raw;
    logic [DATA_W-1:0]                shaped;
    logic                             writes;

    mvx_decode #(
        .OFF_W (OFF_W),
        .IMM_W (IMM_W)
    ) u_dec (
        .opcode  (in_opcode),
        .cls     (in_class),
        .src_reg (in_src_reg),
        .offset  (in_offset),
        .imm     (in_imm),
        .dec     (dec)
    );

    // Purpose: choose register or sign-extended immediate as the operand.
    always_comb begin
        operand = in_src_reg ? in_src
                             : {{(DATA_W - IMM_W){in_imm[IMM_W-1]}}, in_imm};
    end

    mvx_sext #(.DATA_W(DATA_W)) u_sext (
        .op_in   (in_src),
        .ext_out (ext_vals)
    );

    mvx_bswap #(.DATA_W(DATA_W)) u_swap (
        .op_in   (in_dst),
        .swp_out (swp_vals)
    );

    // Purpose: select the raw result for the decoded kind.
    always_comb begin
        case (dec.kind)
            K_MOV:   raw = operand;
            K_SX8:   raw = ext_vals[0];
            K_SX16:  raw = ext_vals[1];
            K_SX32:  raw = ext_vals[2];
            K_NEG:   raw = '0 - in_dst;
            K_SW16:  raw = swp_vals[0];
            K_SW32:  raw = swp_vals[1];
            K_SW64:  raw = swp_vals[2];
            default: raw = '0;
        endcase
    end

    // Purpose: zero the upper half for the 32-bit class.
    always_comb begin
        shaped = dec.narrow ? {{(DATA_W - HALF_W){1'b0}}, raw[HALF_W-1:0]} : raw;
    end

    // Purpose: drive the write-enable, illegal flag and gated result.
    always_comb begin
        writes      = in_valid && (dec.kind != K_NONE) && (dec.kind != K_BAD);
        out_wr_en   = writes;
        out_illegal = in_valid && (dec.kind == K_BAD);
        out_result  = writes ? shaped : '0;
    end

endmodule

// Module: checker for the slice's port relations, bound to every instance.
module mvx_swap_unit_chk #(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input logic              in_valid,
    input logic [3:0]        in_opcode,
    input logic [2:0]        in_class,
    input logic              in_src_reg,
    input logic [OFF_W-1:0]  in_offset,
    input logic [IMM_W-1:0]  in_imm,
    input logic [DATA_W-1:0] out_result,
    input logic              out_wr_en,
    input logic              out_illegal
);

    localparam int HALF_W = DATA_W / 2;

    // Purpose: check output relations whenever any port changes.
    always_comb begin
        if (!in_valid)
            a_r1_idle_quiet: assert (!out_wr_en && !out_illegal && out_result == '0);
        a_r11_wr_ill_exclusive: assert (!(out_wr_en && out_illegal));
        if (!out_wr_en)
            a_r11_result_gated: assert (out_result == '0);
        if (out_wr_en && in_class == 3'h4)
            a_r3_narrow_upper_zero: assert (out_result[DATA_W-1:HALF_W] == '0);
        if (out_wr_en && in_class == 3'h7 && in_opcode == 4'hd && in_imm == IMM_W'(16))
            a_r7_swap16_upper_zero: assert (out_result[DATA_W-1:16] == '0);
        if (out_wr_en && in_class == 3'h7 && in_opcode == 4'hb && in_offset == OFF_W'(8))
            a_r4_sx8_sign_fill: assert (&out_result[DATA_W-1:7] || ~|out_result[DATA_W-1:7]);
        if (in_valid && in_opcode != 4'hb && in_opcode != 4'h8 && in_opcode != 4'hd)
            a_r10_foreign_opcode: assert (!out_wr_en && !out_illegal);
        if (in_valid && in_opcode == 4'hb && in_offset != '0 && !in_src_reg
            && (in_class == 3'h7 || in_class == 3'h4))
            a_r6_imm_ext_illegal: assert (out_illegal);
    end

endmodule

bind mvx_swap_unit mvx_swap_unit_chk #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .IMM_W  (IMM_W)
) u_chk (
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .in_class    (in_class),
    .in_src_reg  (in_src_reg),
    .in_offset   (in_offset),
    .in_imm      (in_imm),
    .out_result  (out_result),
    .out_wr_en   (out_wr_en),
    .out_illegal (out_illegal)
);

// File: tb/sim_mvx_swap_unit.sv
module sim_mvx_swap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_opcode = '0;
    logic [2:0]  in_class = '0;
    logic        in_src_reg = 1'b0;
    logic [15:0] in_offset = '0;
    logic [31:0] in_imm = '0;
    logic [63:0] in_dst = '0;
    logic [63:0] in_src = '0;
    logic [63:0] out_result;
    logic        out_wr_en;
    logic        out_illegal;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic [63:0] res;
        logic        wr;
        logic        ill;
    } exp_t;

    exp_t pending[$];

    always #2 clk = ~clk;

    mvx_swap_unit u0 (
        .in_valid    (in_valid),
        .in_opcode   (in_opcode),
        .in_class    (in_class),
        .in_src_reg  (in_src_reg),
        .in_offset   (in_offset),
        .in_imm      (in_imm),
        .in_dst      (in_dst),
        .in_src      (in_src),
        .out_result  (out_result),
        .out_wr_en   (out_wr_en),
        .out_illegal (out_illegal)
    );

    // Reference: reverse the low nb bytes of v, clear the rest.
    function automatic logic [63:0] rev_bytes(input logic [63:0] v, input int nb);
        logic [63:0] r = '0;
        for (int i = 0; i < nb; i++)
            r[8*i +: 8] = v[8*(nb-1-i) +: 8];
        return r;
    endfunction

    // Driver: present one instruction and queue its expected outputs.
    task automatic drive(input string tag, input logic v, input logic [3:0] op,
                         input logic [2:0] cl, input logic sr, input logic [15:0] off,
                         input logic [31:0] im, input logic [63:0] d,
                         input logic [63:0] s, input logic [63:0] eres,
                         input logic ewr, input logic eill);
        exp_t e;
        @(posedge clk);
        in_valid = v; in_opcode = op; in_class = cl; in_src_reg = sr;
        in_offset = off; in_imm = im; in_dst = d; in_src = s;
        e.tag = tag; e.res = eres; e.wr = ewr; e.ill = eill;
        pending.push_back(e);
    endtask

    // Monitor: pop the expected item and compare with the outputs.
    always @(negedge clk) begin
        if (rst_n && pending.size() > 0) begin
            exp_t e;
            e = pending.pop_front();
            checks++;
            if (out_result !== e.res || out_wr_en !== e.wr || out_illegal !== e.ill) begin
                failures++;
                $display("FAIL %s: got res=%h wr=%b ill=%b, expected res=%h wr=%b ill=%b",
                         e.tag, out_result, out_wr_en, out_illegal, e.res, e.wr, e.ill);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got running, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [63:0] PAT = 64'h1122_3344_5566_7788;

    initial begin
        // R1: idle outputs during reset, checked directly.
        in_opcode = 4'hb; in_class = 3'h7; in_src_reg = 1'b1; in_src = PAT;
        repeat (2) @(negedge clk);
        checks++;
        if (out_result !== 64'h0 || out_wr_en !== 1'b0 || out_illegal !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset idle: got res=%h wr=%b ill=%b, expected 0 0 0",
                     out_result, out_wr_en, out_illegal);
        end
        rst_n = 1'b1;

        drive("R1 invalid move", 0, 4'hb, 3'h7, 1, 16'd0, 32'd0, 64'h0, PAT, 64'h0, 0, 0);
        // R2: plain moves, register and immediate
        drive("R2 mov reg", 1, 4'hb, 3'h7, 1, 16'd0, 32'd0, 64'h0,
              64'h8123_4567_89ab_cdef, 64'h8123_4567_89ab_cdef, 1, 0);
        drive("R2 mov imm neg", 1, 4'hb, 3'h7, 0, 16'd0, 32'hffff_ff80, 64'h0, PAT,
              64'hffff_ffff_ffff_ff80, 1, 0);
        drive("R2 mov imm pos", 1, 4'hb, 3'h7, 0, 16'd0, 32'h7fff_0001, 64'h0, PAT,
              64'h0000_0000_7fff_0001, 1, 0);
        // R3: 32-bit plain move
        drive("R3 mov32 reg", 1, 4'hb, 3'h4, 1, 16'd0, 32'd0, 64'h0,
              64'hdead_beef_8000_0001, 64'h0000_0000_8000_0001, 1, 0);
        drive("R3 mov32 imm", 1, 4'hb, 3'h4, 0, 16'd0, 32'hffff_fffe, 64'h0, PAT,
              64'h0000_0000_ffff_fffe, 1, 0);
        // R4: 64-bit sign-extending moves
        drive("R4 sx8 neg", 1, 4'hb, 3'h7, 1, 16'd8, 32'd0, 64'h0,
              64'h1234_5678_9abc_de80, 64'hffff_ffff_ffff_ff80, 1, 0);
        drive("R4 sx8 pos", 1, 4'hb, 3'h7, 1, 16'd8, 32'd0, 64'h0,
              64'hffff_ffff_ffff_ff7f, 64'h0000_0000_0000_007f, 1, 0);
        drive("R4 sx16 neg", 1, 4'hb, 3'h7, 1, 16'd16, 32'd0, 64'h0,
              64'h0000_0000_0000_8001, 64'hffff_ffff_ffff_8001, 1, 0);
        drive("R4 sx32 neg", 1, 4'hb, 3'h7, 1, 16'd32, 32'd0, 64'h0,
              64'h0000_0000_8000_0000, 64'hffff_ffff_8000_0000, 1, 0);
        drive("R4 sx32 pos", 1, 4'hb, 3'h7, 1, 16'd32, 32'd0, 64'h0,
              64'hffff_ffff_7fff_ffff, 64'h0000_0000_7fff_ffff, 1, 0);
        // R5: 32-bit sign-extending moves
        drive("R5 sx8 narrow", 1, 4'hb, 3'h4, 1, 16'd8, 32'd0, 64'h0,
              64'h0000_0000_0000_0080, 64'h0000_0000_ffff_ff80, 1, 0);
        drive("R5 sx16 narrow", 1, 4'hb, 3'h4, 1, 16'd16, 32'd0, 64'h0,
              64'hffff_ffff_ffff_9000, 64'h0000_0000_ffff_9000, 1, 0);
        drive("R5 sx16 narrow pos", 1, 4'hb, 3'h4, 1, 16'd16, 32'd0, 64'h0,
              64'hffff_ffff_ffff_1234, 64'h0000_0000_0000_1234, 1, 0);
        // R6: unsupported move encodings
        drive("R6 sx32 in narrow", 1, 4'hb, 3'h4, 1, 16'd32, 32'd0, 64'h0, PAT, 64'h0, 0, 1);
        drive("R6 bad offset 4", 1, 4'hb, 3'h7, 1, 16'd4, 32'd0, 64'h0, PAT, 64'h0, 0, 1);
        drive("R6 bad offset 64", 1, 4'hb, 3'h7, 1, 16'd64, 32'd0, 64'h0, PAT, 64'h0, 0, 1);
        drive("R6 offset with imm", 1, 4'hb, 3'h7, 0, 16'd8, 32'h80, 64'h0, PAT, 64'h0, 0, 1);
        // R7: byte swaps of the destination
        for (int k = 0; k < 3; k++) begin
            int nb = 2 << k;
            drive("R7 bswap", 1, 4'hd, 3'h7, 0, 16'd0, 32'(nb * 8), PAT, 64'h0,
                  rev_bytes(PAT, nb), 1, 0);
        end
        drive("R7 bswap16 high clear", 1, 4'hd, 3'h7, 0, 16'd0, 32'h10,
              64'hffff_ffff_ffff_00ff, 64'h0, 64'h0000_0000_0000_ff00, 1, 0);
        // R8: unsupported swap encodings
        drive("R8 bswap imm 0x30", 1, 4'hd, 3'h7, 0, 16'd0, 32'h30, PAT, 64'h0, 64'h0, 0, 1);
        drive("R8 bswap src reg", 1, 4'hd, 3'h7, 1, 16'd0, 32'h40, PAT, 64'h0, 64'h0, 0, 1);
        // R9: negation
        drive("R9 neg64", 1, 4'h8, 3'h7, 0, 16'd0, 32'd0, 64'h1, 64'h0,
              64'hffff_ffff_ffff_ffff, 1, 0);
        drive("R9 neg32", 1, 4'h8, 3'h4, 0, 16'd0, 32'd0, 64'hffff_ffff_0000_0001, 64'h0,
              64'h0000_0000_ffff_ffff, 1, 0);
        drive("R9 neg src reg", 1, 4'h8, 3'h7, 1, 16'd0, 32'd0, 64'h5, 64'h0, 64'h0, 0, 1);
        // R10: encodings belonging to other slices
        drive("R10 add opcode", 1, 4'h0, 3'h7, 1, 16'd0, 32'd0, PAT, PAT, 64'h0, 0, 0);
        drive("R10 other class", 1, 4'hb, 3'h1, 1, 16'd8, 32'd0, 64'h0, PAT, 64'h0, 0, 0);
        drive("R10 narrow end", 1, 4'hd, 3'h4, 0, 16'd0, 32'h40, PAT, 64'h0, 64'h0, 0, 0);
        // R11: no write leaves the result at zero
        drive("R11 illegal gated", 1, 4'hb, 3'h7, 1, 16'd3, 32'd0, 64'h0,
              64'hffff_ffff_ffff_ffff, 64'h0, 0, 1);

        @(posedge clk);
        in_valid = 1'b0;
        while (pending.size() > 0) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule